// File: doc/BRIEF.md
# Banked Glitch-Free Clock Output Gate

This block sits between four independent clock sources and eight clock output pins. Each source feeds one bank, and each bank drives two identical copies of its clock. A bank runs when its own disable control is low and the global disable control is also low. When either control is high, both outputs of that bank stop and stay at logic low.

The control inputs are asynchronous to every bank clock. Each bank therefore resynchronises its own effective disable in its own clock domain and moves its gate only while its clock is low. As a result, an output never shows a shortened high or low pulse when it starts or stops. Reset forces every output low. After reset, every bank stays stopped until its synchronizer has passed the released state through.

Top module: `clk_bank_gate`

## Requirements
- R1: Outputs 2b and 2b+1 carry the clock of bank b. Bank 0 drives outputs 0/1, bank 1 drives 2/3, bank 2 drives 4/5 and bank 3 drives 6/7. `bank_dis[b]` is the disable for bank b.
- R2: When `all_dis` is low, a bank whose `bank_dis` bit is held high drives both of its outputs low. A bank whose bit is held low reproduces its bank clock on both outputs: high during the high phase and low during the low phase.
- R3: While `all_dis` is held high, all eight outputs are low, whatever the value of `bank_dis`.
- R4: Every high pulse on an output lasts exactly one high phase of its bank clock. No low interval is shorter than one low phase. Together these exclude runt pulses when a bank starts or stops. The gate of a bank changes only while that bank's clock is low.
- R5: The two outputs of a bank are equal at all times.
- R6: After the controls change and are then held, each bank shows its new running or stopped state no later than its fourth rising clock edge.
- R7: While `rst_n` is low, all outputs are low. After release, a bank whose controls are low produces no high level until its third rising clock edge: the first two rising edges after release stay low.
- R8: Changing one bank's disable has no effect on the outputs of the other banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bank_clk | input | 4 | Source clock of each bank |
| bank_dis | input | 4 | Per-bank disable, active high (low enables the bank) |
| all_dis | input | 1 | Global disable, active high, covers all banks |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_out | output | 8 | Gated clocks, two per bank |

## Verification
A stuck or wrongly reset synchronizer stage shows up at the ports as a bank that starts or stops one cycle late, or never. The scoreboard sees this within four cycles of that bank's clock. A gate register clocked on the wrong edge, or reset to the running state, produces a high pulse that is cut short or appears too early. The pulse-width monitor flags it on the very next output edge. Miswiring between banks breaks the pairing of the two outputs or the per-bank running state, and this is visible in the first sampled phase after the controls settle.

// File: rtl/clk_bank_gate_pkg.sv
package clk_bank_gate_pkg;
  localparam int DEF_BANKS    = 4;
  localparam int DEF_PER_BANK = 2;
  localparam int DEF_STAGES   = 2;

  // bank that owns a given output index
  function automatic int bank_of(input int out_idx, input int per_bank);
    return out_idx / per_bank;
  endfunction

  // a bank is stopped when the global or its own disable is set
  function automatic logic bank_stopped(input logic glob, input logic own);
    return glob | own;
  endfunction
endpackage

// File: rtl/bank_dis_sync.sv
module bank_dis_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_async,
  output logic dis_sync
);
  logic [STAGES-1:0] chain;

  // reset value 1: the bank counts as stopped until the release propagates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], dis_async};
  end

  assign dis_sync = chain[STAGES-1];
endmodule

// File: rtl/bank_gate_cell.sv
module bank_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_sync,
  output logic gate_on,
  output logic gclk
);
  // updated on the falling edge, so it only moves during the low phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_on <= 1'b0;
    else        gate_on <= ~stop_sync;
  end

  assign gclk = clk & gate_on;
endmodule

// File: rtl/clk_bank_gate.sv
module clk_bank_gate
  import clk_bank_gate_pkg::*;
#(
  parameter int NUM_BANKS   = DEF_BANKS,
  parameter int PER_BANK    = DEF_PER_BANK,
  parameter int SYNC_STAGES = DEF_STAGES
) (
  input  logic [NUM_BANKS-1:0]          bank_clk,
  input  logic [NUM_BANKS-1:0]          bank_dis,
  input  logic                          all_dis,
  input  logic                          rst_n,
  output logic [NUM_BANKS*PER_BANK-1:0] clk_out
);
  localparam int NUM_OUTS = NUM_BANKS * PER_BANK;

  logic [NUM_BANKS-1:0] stop_raw;
  logic [NUM_BANKS-1:0] stop_sync;
  logic [NUM_BANKS-1:0] gate_on;
  logic [NUM_BANKS-1:0] gclk;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign stop_raw[b] = bank_stopped(all_dis, bank_dis[b]);

    bank_dis_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (bank_clk[b]),
      .rst_n    (rst_n),
      .dis_async(stop_raw[b]),
      .dis_sync (stop_sync[b])
    );

    bank_gate_cell u_gate (
      .clk      (bank_clk[b]),
      .rst_n    (rst_n),
      .stop_sync(stop_sync[b]),
      .gate_on  (gate_on[b]),
      .gclk     (gclk[b])
    );
  end

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    assign clk_out[o] = gclk[bank_of(o, PER_BANK)];
  end
endmodule

// File: rtl/clk_bank_gate_chk.sv
module clk_bank_gate_chk #(
  parameter int NUM_BANKS = 4,
  parameter int PER_BANK  = 2
) (
  input logic [NUM_BANKS-1:0]          bank_clk,
  input logic [NUM_BANKS-1:0]          bank_dis,
  input logic                          all_dis,
  input logic                          rst_n,
  input logic [NUM_BANKS*PER_BANK-1:0] clk_out,
  input logic [NUM_BANKS-1:0]          gate_on
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    localparam int LO = b * PER_BANK;

    // R5: outputs of one bank agree in the high phase
    assert_pair_equal_R5: assert property (@(negedge bank_clk[b]) disable iff (!rst_n)
      clk_out[LO] == clk_out[LO+1]);

    // R3: global disable held for several falling edges -> bank low
    assert_global_stop_R3: assert property (@(negedge bank_clk[b]) disable iff (!rst_n)
      (all_dis && $past(all_dis) && $past(all_dis, 2) && $past(all_dis, 3)) |-> !clk_out[LO]);

    // R2: own disable held for several falling edges -> bank low
    assert_bank_stop_R2: assert property (@(negedge bank_clk[b]) disable iff (!rst_n)
      (bank_dis[b] && $past(bank_dis[b]) && $past(bank_dis[b], 2) && $past(bank_dis[b], 3))
      |-> !clk_out[LO+1]);

    // R7: reset holds the bank outputs low
    assert_reset_low_R7: assert property (@(negedge bank_clk[b])
      !rst_n |-> (clk_out[LO] == 1'b0 && clk_out[LO+1] == 1'b0));

    // R4: the gate moves only while the bank clock is low
    always @(gate_on[b]) begin
      if (rst_n === 1'b1) begin
        assert_gate_in_low_phase_R4: assert (bank_clk[b] == 1'b0);
      end
    end
  end
endmodule

bind clk_bank_gate clk_bank_gate_chk #(.NUM_BANKS(NUM_BANKS), .PER_BANK(PER_BANK)) u_chk (
  .bank_clk(bank_clk),
  .bank_dis(bank_dis),
  .all_dis (all_dis),
  .rst_n   (rst_n),
  .clk_out (clk_out),
  .gate_on (gate_on)
);

// File: tb/clk_bank_gate_bench.sv
`timescale 1ns/1ps
module clk_bank_gate_bench;
  logic [3:0] bclk = '0;
  logic [3:0] bank_dis = '0;
  logic       all_dis = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  clk_bank_gate u_clk_bank_gate (
    .bank_clk(bclk), .bank_dis(bank_dis), .all_dis(all_dis),
    .rst_n(rst_n), .clk_out(clk_out)
  );

  // 250 MHz on bank 0, slower independent clocks on the others
  initial forever #2 bclk[0] = ~bclk[0];
  initial forever #3 bclk[1] = ~bclk[1];
  initial forever #5 bclk[2] = ~bclk[2];
  initial forever #7 bclk[3] = ~bclk[3];

  function automatic real half_of(input int b);
    case (b)
      0: return 2.0;
      1: return 3.0;
      2: return 5.0;
      default: return 7.0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_rise(input int b);
    case (b)
      0: @(posedge bclk[0]);
      1: @(posedge bclk[1]);
      2: @(posedge bclk[2]);
      default: @(posedge bclk[3]);
    endcase
  endtask

  task automatic wait_fall(input int b);
    case (b)
      0: @(negedge bclk[0]);
      1: @(negedge bclk[1]);
      2: @(negedge bclk[2]);
      default: @(negedge bclk[3]);
    endcase
  endtask

  // scoreboard
  typedef struct { int bank; bit on; } exp_t;
  exp_t sb_q[$];

  task automatic apply(input bit m, input logic [3:0] d);
    all_dis  = m;
    bank_dis = d;
    for (int b = 0; b < 4; b++) begin
      exp_t e;
      e.bank = b;
      e.on   = !(m | d[b]);
      sb_q.push_back(e);
    end
    wait (sb_q.size() == 0);
  endtask

  // monitor: pops expected states and compares the bank's outputs
  initial begin
    forever begin
      exp_t e;
      real h;
      wait (sb_q.size() != 0);
      e = sb_q[0];
      h = half_of(e.bank);
      // R6: new state settled by the fourth rising edge
      for (int k = 0; k < 4; k++) wait_rise(e.bank);
      for (int k = 0; k < 3; k++) begin
        #(h / 2.0);
        chk(clk_out[2*e.bank] == e.on, "R2/R3/R6/R8 high phase", int'(clk_out[2*e.bank]), int'(e.on));
        chk(clk_out[2*e.bank] == clk_out[2*e.bank+1], "R1/R5 pair", int'(clk_out[2*e.bank+1]), int'(clk_out[2*e.bank]));
        wait_fall(e.bank);
        #(h / 2.0);
        chk(clk_out[2*e.bank] == 1'b0 && clk_out[2*e.bank+1] == 1'b0, "R2 low phase",
            int'(clk_out[2*e.bank+:2]), 0);
        wait_rise(e.bank);
      end
      void'(sb_q.pop_front());
    end
  end

  // R4 pulse-width monitor on every output
  for (genvar g = 0; g < 8; g++) begin : g_pw
    initial begin
      realtime t_r, t_f;
      real h;
      bit seen_fall;
      h = half_of(g / 2);
      seen_fall = 0;
      t_r = 0;
      t_f = 0;
      wait (rst_n === 1'b1);
      forever begin
        @(clk_out[g]);
        if (clk_out[g] === 1'b1) begin
          t_r = $realtime;
          if (seen_fall)
            chk(t_r - t_f >= h - 0.01, "R4 low width", int'((t_r - t_f) * 1000), int'(h * 1000));
        end else if (clk_out[g] === 1'b0 && t_r > 0) begin
          t_f = $realtime;
          seen_fall = 1;
          chk((t_f - t_r > h - 0.01) && (t_f - t_r < h + 0.01), "R4 high width",
              int'((t_f - t_r) * 1000), int'(h * 1000));
        end
      end
    end
  end

  // watchdog
  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R7: reset holds everything low
    #21.3;
    chk(clk_out == 8'h00, "R7 reset low", int'(clk_out), 0);
    #6.1;
    chk(clk_out == 8'h00, "R7 reset low later", int'(clk_out), 0);
    @(negedge bclk[0]);
    #0.5 rst_n = 1'b1;
    // R7: first two rising edges after release stay low on bank 0
    @(posedge bclk[0]); #1;
    chk(clk_out[1:0] == 2'b00, "R7 first edge low", int'(clk_out[1:0]), 0);
    @(posedge bclk[0]); #1;
    chk(clk_out[1:0] == 2'b00, "R7 second edge low", int'(clk_out[1:0]), 0);
    @(posedge bclk[0]); #1;
    chk(clk_out[1:0] == 2'b11, "R7 third edge runs", int'(clk_out[1:0]), 3);

    apply(1'b0, 4'b0000);   // all run
    apply(1'b0, 4'b0010);   // R8: only bank 1 stopped
    apply(1'b0, 4'b1010);   // banks 1 and 3 stopped
    apply(1'b1, 4'b0000);   // R3: global stop
    apply(1'b1, 4'b0101);   // R3 with mixed bank bits
    apply(1'b0, 4'b0101);   // global released, own bits hold
    apply(1'b0, 4'b0000);

    // R4 stress: toggle bank 2 at awkward times
    for (int k = 0; k < 6; k++) begin
      #(3.7 + k);
      bank_dis[2] = ~bank_dis[2];
    end
    #1.3 all_dis = 1'b1;
    #2.9 all_dis = 1'b0;
    apply(1'b0, 4'b0000);
    apply(1'b0, 4'b1111);   // R2: every bank stopped by its own bit
    apply(1'b0, 4'b0000);

    #50;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule